// File: doc/BRIEF.md
# Banked Program Store with Operator Panel

This block holds the instruction words of a small processor. It has a synchronous memory of 2048 words of 5 bits each. One 5-bit word holds any opcode or operand. The memory address is split into two parts. The upper 3 bits come from an operator-set bank select, which chooses one of 8 separate programs. The lower 8 bits are an offset inside that program, so each program holds up to 256 words.

The offset normally comes from a program counter. The counter is built from two chained 4-bit sections, and the low section's carry advances the high section. The counter can step by one, or it can take a parallel value in one cycle so that jump commands can redirect it.

An operator panel lets a person enter and inspect programs. A mode switch selects programming. In programming mode the read output is blanked, and each rising edge of the write button stores the 5-bit panel value at the current address. When the mode switch is off, the output is live and the button has no effect. A manual-address switch takes the counter off the address path and uses eight panel address switches instead.

Top module: `pgm_store`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pc_value` is 0 and `rd_data` is 0.
- R2: When `pc_inc` is 1 and `pc_load` is 0, `pc_value` becomes its old value plus 1 (modulo 256) one clock later. The carry out of the low nibble (0x0F to 0x10) advances the high nibble, and 0xFF wraps to 0x00.
- R3: When `pc_load` is 1, `pc_value` becomes `pc_load_val` one clock later, whatever the value of `pc_inc`.
- R4: When `pc_load` and `pc_inc` are both 0, `pc_value` keeps its value.
- R5: When `man_mode` is 0 and `prog_mode` is 0, the read address is {`bank_sel`, `pc_value`}. `rd_data` shows the word at the address sampled at the previous clock edge, so the read latency is one cycle.
- R6: When `man_mode` is 1, the address offset is `man_addr`. The counter still obeys `pc_inc` and `pc_load`, but it does not drive the address.
- R7: When `prog_mode` is 1, a 0-to-1 change of `wr_btn` writes `panel_data` to the current address at that clock edge. Holding the button high writes exactly once.
- R8: When `prog_mode` is 0, `wr_btn` never changes memory contents.
- R9: `rd_data` is 0 in every cycle that follows a clock edge at which `prog_mode` was 1.
- R10: The 8 banks are independent. A write at an offset in one bank leaves the same offset in every other bank unchanged.
- R11: A write and a counter step in the same cycle use the pre-step address. The word at the stepped-to address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 3 | Program bank select (upper address bits) |
| pc_inc | input | 1 | Step the program counter by one |
| pc_load | input | 1 | Load the program counter in parallel (has priority over step) |
| pc_load_val | input | 8 | Value for the parallel load |
| prog_mode | input | 1 | 1 = programming (output blanked, writes allowed), 0 = run/inspect |
| panel_data | input | 5 | Word to be stored by the write button |
| wr_btn | input | 1 | Write button level; the rising edge writes |
| man_mode | input | 1 | 1 = panel switches supply the address offset |
| man_addr | input | 8 | Panel address offset |
| rd_data | output | 5 | Registered read word |
| pc_value | output | 8 | Current program counter |

## Verification
A write strobe and a counter step can fall in the same clock edge. The write must land at the address that was present before the step. The bench sets up this case by loading the counter to 0x3F in bank 2 and preloading 0x40 with a known word. It then raises the button and the step input together. Both offsets are read back in manual mode: the new word must be at 0x3F, the old word must still be at 0x40, and the counter must read 0x40.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  parameter int unsigned NIB_W = 4;

  typedef enum logic {
    SRC_COUNTER = 1'b0,
    SRC_PANEL   = 1'b1
  } addr_src_e;

endpackage

// File: rtl/pgm_nib_ctr.sv
module pgm_nib_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         cin,
  output logic [W-1:0] q,
  output logic         cout
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (cin) begin
      q <= q + W'(1);
    end
  end

  // carry ripples only when this section is enabled and saturated
  assign cout = cin && (q == ALL_ONES);

endmodule

// File: rtl/pgm_counter.sv
module pgm_counter #(
  parameter int unsigned PC_W  = 8,
  parameter int unsigned SEC_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            load,
  input  logic [PC_W-1:0] load_val,
  output logic [PC_W-1:0] pc
);

  localparam int unsigned N_SEC = PC_W / SEC_W;

  logic [N_SEC:0] carry;

  assign carry[0] = inc && !load;

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    pgm_nib_ctr #(.W(SEC_W)) i_sec (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (load_val[s*SEC_W +: SEC_W]),
      .cin      (carry[s]),
      .q        (pc[s*SEC_W +: SEC_W]),
      .cout     (carry[s+1])
    );
  end

  // R2 step by one across the chained sections
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (pc == $past(pc) + PC_W'(1)));

  // R3 parallel load wins
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (pc == $past(load_val)));

  // R4 idle hold
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(pc));

endmodule

// File: rtl/pgm_strobe.sv
module pgm_strobe (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic pulse
);

  logic btn_q;

  always_ff @(posedge clk) begin
    if (rst) btn_q <= 1'b0;
    else     btn_q <= btn;
  end

  assign pulse = btn && !btn_q;

  // R7 one press yields a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

endmodule

// File: rtl/pgm_addr_sel.sv
module pgm_addr_sel
  import pgm_pkg::*;
#(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned BANK_W = 3
) (
  input  addr_src_e                src,
  input  logic [BANK_W-1:0]        bank,
  input  logic [PC_W-1:0]          pc,
  input  logic [PC_W-1:0]          panel_addr,
  output logic [BANK_W+PC_W-1:0]   addr
);

  logic [PC_W-1:0] offset;

  always_comb begin
    unique case (src)
      SRC_PANEL:   offset = panel_addr;
      default:     offset = pc;
    endcase
  end

  assign addr = {bank, offset};

endmodule

// File: rtl/pgm_mem.sv
module pgm_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // single port, read-first, no reset: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (re) rdata <= store[addr];
  end

endmodule

// File: rtl/pgm_store.sv
module pgm_store
  import pgm_pkg::*;
#(
  parameter int unsigned DATA_W = 5,
  parameter int unsigned PC_W   = 8,
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              pc_inc,
  input  logic              pc_load,
  input  logic [PC_W-1:0]   pc_load_val,
  input  logic              prog_mode,
  input  logic [DATA_W-1:0] panel_data,
  input  logic              wr_btn,
  input  logic              man_mode,
  input  logic [PC_W-1:0]   man_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PC_W-1:0]   pc_value
);

  localparam int unsigned ADDR_W = BANK_W + PC_W;

  logic [PC_W-1:0]   pc;
  logic              wr_pulse;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_q;
  logic              out_en_q;
  addr_src_e         src;

  pgm_counter #(.PC_W(PC_W), .SEC_W(NIB_W)) i_pc (
    .clk      (clk),
    .rst      (rst),
    .inc      (pc_inc),
    .load     (pc_load),
    .load_val (pc_load_val),
    .pc       (pc)
  );

  pgm_strobe i_wr_edge (
    .clk   (clk),
    .rst   (rst),
    .btn   (wr_btn),
    .pulse (wr_pulse)
  );

  assign src = man_mode ? SRC_PANEL : SRC_COUNTER;

  pgm_addr_sel #(.PC_W(PC_W), .BANK_W(BANK_W)) i_addr (
    .src        (src),
    .bank       (bank_sel),
    .pc         (pc),
    .panel_addr (man_addr),
    .addr       (mem_addr)
  );

  pgm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk   (clk),
    .we    (wr_pulse && prog_mode),
    .re    (!prog_mode),
    .addr  (mem_addr),
    .wdata (panel_data),
    .rdata (mem_q)
  );

  // output qualifier registered beside the RAM data register
  always_ff @(posedge clk) begin
    if (rst) out_en_q <= 1'b0;
    else     out_en_q <= !prog_mode;
  end

  assign rd_data  = out_en_q ? mem_q : '0;
  assign pc_value = pc;

  // R9 programming mode blanks the read port on the next cycle
  a_r9_blank: assert property (@(posedge clk) disable iff (rst)
    prog_mode |=> (rd_data == '0));

  // R1 counter cleared right after reset
  a_r1_reset_pc: assert property (@(posedge clk)
    rst |=> (pc_value == '0));

endmodule

// File: tb/test_pgm_store.sv
module test_pgm_store;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bank_sel = '0;
  logic       pc_inc = 1'b0;
  logic       pc_load = 1'b0;
  logic [7:0] pc_load_val = '0;
  logic       prog_mode = 1'b0;
  logic [4:0] panel_data = '0;
  logic       wr_btn = 1'b0;
  logic       man_mode = 1'b0;
  logic [7:0] man_addr = '0;
  logic [4:0] rd_data;
  logic [7:0] pc_value;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pgm_store i_pgm_store (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .pc_inc(pc_inc),
    .pc_load(pc_load), .pc_load_val(pc_load_val), .prog_mode(prog_mode),
    .panel_data(panel_data), .wr_btn(wr_btn), .man_mode(man_mode),
    .man_addr(man_addr), .rd_data(rd_data), .pc_value(pc_value)
  );

  // entry = {bank, offset, word}
  localparam logic [15:0] VEC [8] = '{
    {3'd0, 8'h00, 5'h15}, {3'd7, 8'hFF, 5'h0A},
    {3'd1, 8'h00, 5'h1F}, {3'd2, 8'h00, 5'h03},
    {3'd3, 8'h80, 5'h11}, {3'd5, 8'h0F, 5'h10},
    {3'd5, 8'h10, 5'h01}, {3'd6, 8'h3C, 5'h1E}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pwrite(input logic [2:0] b, input logic [7:0] a, input logic [4:0] d);
    prog_mode = 1'b1; man_mode = 1'b1; bank_sel = b; man_addr = a;
    panel_data = d; wr_btn = 1'b1;
    cyc();
    wr_btn = 1'b0;
    cyc();
  endtask

  task automatic pread(input logic [2:0] b, input logic [7:0] a, output logic [4:0] d);
    prog_mode = 1'b0; man_mode = 1'b1; bank_sel = b; man_addr = a;
    cyc();
    d = rd_data;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [4:0] r;
    cyc(); cyc();
    // R1 reset state while rst is high
    chk("R1 pc", pc_value, 0);
    chk("R1 rd_data", rd_data, 0);
    rst = 1'b0;
    cyc();
    chk("R1 pc after release", pc_value, 0);

    // vector table: program then read back, R7 R10 R6
    for (int i = 0; i < 8; i++) pwrite(VEC[i][15:13], VEC[i][12:5], VEC[i][4:0]);
    for (int i = 0; i < 8; i++) begin
      pread(VEC[i][15:13], VEC[i][12:5], r);
      chk("R10 bank readback", r, VEC[i][4:0]);
    end

    // R3 load has priority over step
    man_mode = 1'b0; prog_mode = 1'b0;
    pc_load = 1'b1; pc_load_val = 8'h0E; pc_inc = 1'b1;
    cyc();
    pc_load = 1'b0;
    chk("R3 load priority", pc_value, 8'h0E);
    cyc();
    chk("R2 step", pc_value, 8'h0F);
    cyc();
    pc_inc = 1'b0;
    chk("R2 nibble carry", pc_value, 8'h10);
    cyc(); cyc();
    chk("R4 hold", pc_value, 8'h10);
    pc_load = 1'b1; pc_load_val = 8'hFF;
    cyc();
    pc_load = 1'b0; pc_inc = 1'b1;
    cyc();
    pc_inc = 1'b0;
    chk("R2 wrap", pc_value, 8'h00);

    // R5 counter-addressed read, one-cycle latency
    bank_sel = 3'd5; pc_load = 1'b1; pc_load_val = 8'h0F;
    cyc();
    pc_load = 1'b0;
    cyc();
    chk("R5 read at pc", rd_data, 5'h10);
    pc_inc = 1'b1;
    cyc();
    pc_inc = 1'b0;
    chk("R5 old word one cycle", rd_data, 5'h10);
    cyc();
    chk("R5 new word", rd_data, 5'h01);

    // R6 manual mode: panel address used, counter still steps
    pc_load = 1'b1; pc_load_val = 8'h20;
    cyc();
    pc_load = 1'b0;
    man_mode = 1'b1; bank_sel = 3'd0; man_addr = 8'h00; pc_inc = 1'b1;
    cyc();
    pc_inc = 1'b0;
    chk("R6 panel address data", rd_data, 5'h15);
    chk("R6 counter still steps", pc_value, 8'h21);

    // R8 writes ignored outside programming mode
    prog_mode = 1'b0; man_mode = 1'b1; bank_sel = 3'd0; man_addr = 8'h00;
    panel_data = 5'h07; wr_btn = 1'b1;
    cyc();
    wr_btn = 1'b0;
    cyc();
    pread(3'd0, 8'h00, r);
    chk("R8 word unchanged", r, 5'h15);

    // R7 held button writes once
    prog_mode = 1'b1; man_mode = 1'b1; bank_sel = 3'd4; man_addr = 8'h22;
    panel_data = 5'h09; wr_btn = 1'b1;
    cyc();
    panel_data = 5'h14;
    cyc(); cyc();
    // R9 output blanked during programming
    chk("R9 blank output", rd_data, 0);
    wr_btn = 1'b0;
    cyc();
    pread(3'd4, 8'h22, r);
    chk("R7 single write", r, 5'h09);

    // R11 write and step in the same cycle
    pwrite(3'd2, 8'h40, 5'h11);
    man_mode = 1'b0; prog_mode = 1'b1; bank_sel = 3'd2;
    pc_load = 1'b1; pc_load_val = 8'h3F;
    cyc();
    pc_load = 1'b0; panel_data = 5'h0C; wr_btn = 1'b1; pc_inc = 1'b1;
    cyc();
    wr_btn = 1'b0; pc_inc = 1'b0;
    cyc();
    chk("R11 counter stepped", pc_value, 8'h40);
    pread(3'd2, 8'h3F, r);
    chk("R11 write at old address", r, 5'h0C);
    pread(3'd2, 8'h40, r);
    chk("R11 next address untouched", r, 5'h11);

    done = 1'b1;
    summary();
  end

endmodule